// File: doc/BRIEF.md
# Johnson Decade Counter with Seven-Segment Decode

This block counts clock edges modulo ten and presents the count in three forms at once: ten one-hot decoded lines, seven active-high segment drives for a numeric display, and a carry output that runs at one tenth of the counting rate. It is meant to be used as one stage of a multi-digit counter, with the carry of one stage clocking the next.

The count is not kept in binary. It is held in a twisted-ring shift register of `STAGES` flip-flops (five by default). Each clock shifts the register one place and feeds the inverted top bit back into the bottom. That gives a sequence of `2*STAGES` states in which any two neighbouring positions change one bit at a time. Because of this sequence, every state can be picked out by a gate that looks at just two register bits. The carry is simply the inverted top bit. An inhibit input freezes the count. A synchronous active-low reset returns the count to zero. A register value that is not in the sequence is replaced by zero on the next clock.

Top module: `jdc_decade_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the count becomes 0 after that edge, whatever `inhibit` is: `dec_line` = 1 (bit 0 only), `seg` shows digit 0, and `carry_out` is 1.
- R2: With `rst_n` high and `inhibit` low, each rising clock edge advances the count by exactly one.
- R3: With `inhibit` high, a rising clock edge leaves the count and every output unchanged.
- R4: The count advances from 9 to 0, so the counter has a modulus of ten.
- R5: `carry_out` is 1 for counts 0 to 4 and 0 for counts 5 to 9. It rises only on the step from 9 to 0, so in free counting it rises once every ten clocks.
- R6: `dec_line` is one-hot, and bit k is set exactly when the count is k.
- R7: `seg` bit 0 drives segment a (top), bit 1 b (upper right), bit 2 c (lower right), bit 3 d (bottom), bit 4 e (lower left), bit 5 f (upper left) and bit 6 g (middle). A 1 lights the segment. The lit sets are: 0 = a b c d e f; 1 = b c; 2 = a b d e g; 3 = a b c d g; 4 = b c f g; 5 = a c d f g; 6 = a c d e f g; 7 = a b c; 8 = all seven; 9 = a b c d f g.
- R8: The state steps through 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000 and then repeats, for counts 0 to 9. Each decoded line is formed from two state bits. Only these states are ever held, and any other value is replaced by 00000 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock; the count changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| inhibit | input | 1 | When high, clock edges do not advance the count |
| seg | output | 7 | Segment drives, bit 0 = a through bit 6 = g, active high |
| dec_line | output | 2*STAGES | One-hot decoded count |
| carry_out | output | 1 | High for counts 0 to 4; rises on the wrap to 0 |

## Verification
The bench builds the counter with its default of five stages, which gives the ten-state decimal sequence. This setting makes every count, every digit pattern and both carry levels reachable in a few hundred clocks. The sweeps run the counter freely through many full cycles, stop it with inhibit at every count, apply reset both at arbitrary counts and together with inhibit, and mix random inhibit patterns, all against an arithmetic model taken modulo ten. The state register cannot be reached from the ports, so the rule that only legal states are held is guarded by an assertion next to the register.

// File: rtl/jdc_pkg.sv
// Shared definitions for the Johnson decade counter.
// Assumes segment vectors are ordered bit 0 = a .. bit 6 = g, active high.
package jdc_pkg;

    localparam int SEG_W = 7;

    typedef logic [SEG_W-1:0] seg_t;

    // Map a decimal digit to its lit segments; non-digits give a dark display.
    function automatic seg_t digit_to_seg(input int unsigned digit);
        seg_t s;
        case (digit)
            0:       s = 7'b0111111;
            1:       s = 7'b0000110;
            2:       s = 7'b1011011;
            3:       s = 7'b1001111;
            4:       s = 7'b1100110;
            5:       s = 7'b1101101;
            6:       s = 7'b1111101;
            7:       s = 7'b0000111;
            8:       s = 7'b1111111;
            9:       s = 7'b1101111;
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/jdc_state_reg.sv
// Twisted-ring state register.
// Each enabled clock shifts the register left and feeds the inverted top
// bit into bit 0. Any value that is not a legal ring state (more than one
// change between adjacent bits) is replaced by all zeros on the next edge,
// inhibited or not. Assumes STAGES >= 2.
module jdc_state_reg #(
    parameter int STAGES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inhibit,
    output logic [STAGES-1:0] state
);

    logic [STAGES-1:0] state_nxt;
    logic              legal;
    int unsigned       bit_changes;

    // Count the boundaries between adjacent bits; a legal ring state has at most one.
    always_comb begin
        bit_changes = 0;
        for (int i = 0; i < STAGES - 1; i++) begin
            bit_changes += 32'(state[i] ^ state[i+1]);
        end
        legal = (bit_changes <= 1);
    end

    // Pick the next state: recover, hold, or shift with inverted feedback.
    always_comb begin
        if (!legal) begin
            state_nxt = '0;
        end else if (inhibit) begin
            state_nxt = state;
        end else begin
            state_nxt = {state[STAGES-2:0], ~state[STAGES-1]};
        end
    end

    // State flops with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
        end else begin
            state <= state_nxt;
        end
    end

    // R8: after reset only legal ring states are ever held.
    p_state_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        legal);

    // R3: an inhibited edge leaves the register untouched.
    p_inhibit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> $stable(state));

endmodule

// File: rtl/jdc_line_decode.sv
// Decodes the twisted-ring state into one-hot count lines.
// Each line is the AND of two state bits (true or inverted) that form a
// unique pair in the sequence. Count 0 is the all-zeros state. Counts 1 to
// STAGES-1 sit at the 1-to-0 boundary, count STAGES is all ones, and the
// later counts sit at the 0-to-1 boundary. Clock and reset are used only by
// the checks.
module jdc_line_decode #(
    parameter int STAGES = 5,
    parameter int LINES  = 2 * STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAGES-1:0] state,
    output logic [LINES-1:0]  line
);

    // One two-input gate per count, chosen by where the count falls in the ring.
    for (genvar k = 0; k < LINES; k++) begin : g_line
        if (k == 0) begin : g_all_zero
            assign line[k] = ~state[STAGES-1] & ~state[0];
        end else if (k < STAGES) begin : g_filling
            assign line[k] = state[k-1] & ~state[k];
        end else if (k == STAGES) begin : g_all_one
            assign line[k] = state[STAGES-1] & state[0];
        end else begin : g_draining
            assign line[k] = ~state[k-STAGES-1] & state[k-STAGES];
        end
    end

    // R6: exactly one count line is active.
    p_line_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(line) == 1);

endmodule

// File: rtl/jdc_seg_encode.sv
// Turns one-hot count lines into seven-segment drives.
// Line k lights the pattern of digit k mod 10. Assumes the lines are one-hot.
module jdc_seg_encode
    import jdc_pkg::*;
#(
    parameter int LINES = 10
) (
    input  logic [LINES-1:0] line,
    output seg_t             seg
);

    // OR together the pattern of whichever line is active.
    always_comb begin
        seg = '0;
        for (int k = 0; k < LINES; k++) begin
            if (line[k]) begin
                seg |= digit_to_seg(32'(k % 10));
            end
        end
    end

endmodule

// File: rtl/jdc_decade_counter.sv
// Johnson decade counter stage with one-hot and seven-segment outputs.
// Holds its count in a STAGES-bit twisted ring (ten counts for the default
// of five). It decodes the ring into one-hot lines and segment drives, and
// gives a carry for the next stage. Assumes a synchronous active-low reset
// and an inhibit input that is synchronous to clk.
module jdc_decade_counter
    import jdc_pkg::*;
#(
    parameter  int STAGES = 5,
    localparam int LINES  = 2 * STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inhibit,
    output logic [SEG_W-1:0] seg,
    output logic [LINES-1:0] dec_line,
    output logic             carry_out
);

    logic [STAGES-1:0] ring;

    jdc_state_reg #(
        .STAGES (STAGES)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .inhibit (inhibit),
        .state   (ring)
    );

    jdc_line_decode #(
        .STAGES (STAGES),
        .LINES  (LINES)
    ) u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .state (ring),
        .line  (dec_line)
    );

    jdc_seg_encode #(
        .LINES (LINES)
    ) u_seg (
        .line (dec_line),
        .seg  (seg)
    );

    // Carry is high for the first half of the cycle, so it rises on the wrap.
    assign carry_out = ~ring[STAGES-1];

    // R2: an enabled edge moves the active line up by one place.
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit |=> dec_line == {$past(dec_line[LINES-2:0]), $past(dec_line[LINES-1])});

    // R4: from the last count an enabled edge returns to count 0.
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_line[LINES-1] && !inhibit) |=> dec_line[0]);

    // R5: carry rises only when the count has just wrapped to 0.
    p_carry_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carry_out) |-> dec_line[0]);

    // R7: count 1 lights only segments b and c.
    p_seg_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_line[1] |-> seg == 7'b0000110);

endmodule

// File: tb/test_jdc_decade_counter.sv
`timescale 1ns/1ps
module test_jdc_decade_counter;

    localparam int    LINES   = 10;
    localparam time   T_CLK   = 20ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             inhibit = 1'b0;
    logic [6:0]       seg;
    logic [LINES-1:0] dec_line;
    logic             carry_out;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    logic prev_carry = 1'b1;
    int   carry_rises = 0;

    always #(T_CLK/2) clk = ~clk;

    jdc_decade_counter i_jdc_decade_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .inhibit   (inhibit),
        .seg       (seg),
        .dec_line  (dec_line),
        .carry_out (carry_out)
    );

    // Segment patterns from the digit table, bit 0 = a .. bit 6 = g.
    function automatic logic [6:0] exp_seg(input int d);
        case (d)
            0: return 7'b0111111;
            1: return 7'b0000110;
            2: return 7'b1011011;
            3: return 7'b1001111;
            4: return 7'b1100110;
            5: return 7'b1101101;
            6: return 7'b1111101;
            7: return 7'b0000111;
            8: return 7'b1111111;
            9: return 7'b1101111;
            default: return 7'b0000000;
        endcase
    endfunction

    task automatic check_val(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (count %0d)", req, actual, expected, exp_cnt);
        end
    endtask

    // Compare every output against the model count.
    task automatic check_outputs(input string req);
        check_val({req, "/R6 lines"}, int'(dec_line), 1 << exp_cnt);
        check_val({req, "/R7 seg"}, int'(seg), int'(exp_seg(exp_cnt)));
        check_val({req, "/R5 carry"}, int'(carry_out), (exp_cnt < 5) ? 1 : 0);
    endtask

    // One clock: inputs set away from the edge, results sampled 2 ns after it.
    task automatic cycle(input logic rst_val, input logic inh_val, input string req);
        rst_n   = rst_val;
        inhibit = inh_val;
        @(posedge clk);
        #2ns;
        if (!rst_val)      exp_cnt = 0;
        else if (!inh_val) exp_cnt = (exp_cnt + 1) % 10;
        if (carry_out && !prev_carry) carry_rises++;
        prev_carry = carry_out;
        check_outputs(req);
    endtask

    initial begin
        #(T_CLK * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state, with inhibit both low and high.
        cycle(1'b0, 1'b0, "R1 reset");
        cycle(1'b0, 1'b1, "R1 reset with inhibit");
        cycle(1'b0, 1'b0, "R1 reset");

        // R2 R4 R8: free count over many full cycles, which covers every wrap.
        carry_rises = 0;
        prev_carry  = carry_out;
        for (int i = 0; i < 100; i++) cycle(1'b1, 1'b0, "R2 free count");
        // R5: one carry rise per ten clocks of free counting.
        check_val("R5 carry rises", carry_rises, 10);

        // R3: hold at every count for several inhibited edges.
        for (int d = 0; d < 10; d++) begin
            for (int h = 0; h < 3; h++) cycle(1'b1, 1'b1, "R3 inhibit hold");
            cycle(1'b1, 1'b0, "R2 step after hold");
        end

        // R4: walk to count 9, hold, then wrap.
        while (exp_cnt != 9) cycle(1'b1, 1'b0, "R2 walk");
        cycle(1'b1, 1'b1, "R3 hold at 9");
        cycle(1'b1, 1'b0, "R4 wrap to 0");
        check_val("R4 wrap count", int'(dec_line), 1);

        // R1: reset from each count in turn.
        for (int d = 1; d < 10; d++) begin
            for (int s = 0; s < d; s++) cycle(1'b1, 1'b0, "R2 advance");
            cycle(1'b0, 1'b1, "R1 reset mid count");
        end

        // R2 R3: random inhibit pattern.
        for (int i = 0; i < 300; i++) cycle(1'b1, 1'($urandom % 2), "R3 random inhibit");

        // R5 R8: carry edge count under a sparse enable.
        carry_rises = 0;
        prev_carry  = carry_out;
        for (int i = 0; i < 200; i++) cycle(1'b1, (i % 2) == 1, "R8 half rate");
        check_val("R5 carry rises half rate", carry_rises, 10);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule